// File: doc/BRIEF.md
# Trace Register Access Scan Chain

This block is a test-data-register path placed behind a JTAG TAP controller. Through it a debug host reads and writes the small register file of an on-chip trace buffer. The TAP state machine is outside the block: it supplies the current instruction and one-cycle capture, shift and update strobes, all qualified to the register-file clock. Reaching the access path takes two steps. The host first loads instruction 0x2 and shifts chain number 0 into a 5-bit chain-select register. It then loads instruction 0xC, which opens the 40-bit access register.

Each access scan carries a write/read flag, a register address and a 32-bit data word. When the update strobe arrives, the block issues one access to the register file. Reads are pipelined: the word a read scan asks for is shifted out in the data field of the next scan. Reading the trace data window (address 4) pops one entry. A host that reads a burst of entries therefore ends the burst with a scan addressed to a register whose read has no side effect, such as address 0. Addresses beyond the implemented register count never reach the register file.

Top module: `trace_reg_scan`

## Requirements
- R1: During and after reset, no access strobe is issued, `tdo` is 0, and the chain select holds all ones. An update at instruction 0xC therefore does nothing until chain 0 has been selected.
- R2: Under instruction 0x2, the 5-bit chain-select register shifts LSB first. Capture loads it with the current chain number, and update makes the shifted value the current chain number.
- R3: Capture, shift and update act on the access register only when the instruction is 0xC and the current chain number is 0. Under any other instruction or chain, no access is issued.
- R4: The access register is 40 bits and shifts LSB first. Bits 31:0 hold the data, bits 38:32 the register address, and bit 39 the flag (1 = write, 0 = read).
- R5: An update whose flag is 1 and whose address is below NUM_REGS (9) drives `acc_valid` high for exactly one cycle, starting the cycle after the update strobe. In that cycle `acc_write` is 1 and `acc_addr` and `acc_wdata` carry the scanned fields.
- R6: An update whose flag is 0 issues a one-cycle read strobe with `acc_write` 0. The `acc_rdata` value in that cycle appears in bits 31:0 of the next capture, and bits 39:32 of that capture are 0.
- R7: An update addressed at NUM_REGS or above issues no strobe. If it is a read, the next capture returns 0 in the data field.
- R8: A write access leaves the held read result unchanged, so the next capture still returns the data from the last read.
- R9: N consecutive reads of address 4 followed by a read of address 0 return N successive window entries in order and pop the window exactly N times.
- R10: `tdo` is bit 0 of the chain-select register under instruction 0x2 and bit 0 of the access register when that path is active. Otherwise it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-file clock; TAP strobes are qualified to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_code | input | 4 | Current TAP instruction |
| capture_dr | input | 1 | One-cycle capture strobe |
| shift_dr | input | 1 | Shift enable, one bit per cycle |
| update_dr | input | 1 | One-cycle update strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out |
| acc_valid | output | 1 | One-cycle register-file access strobe |
| acc_write | output | 1 | Access direction, 1 = write |
| acc_addr | output | 7 | Register address of the access |
| acc_wdata | output | 32 | Write data of the access |
| acc_rdata | input | 32 | Read data from the register file, valid while acc_valid |

## Verification
On every cycle, the assertions check that an access strobe lasts exactly one cycle and follows an update made under the access instruction. They also check that a strobe never carries an unimplemented address, that reset holds the strobe low, and that a write leaves the held read result alone. The remaining behaviour is visible only through whole scans in the bench's scenarios. This covers the bit layout of the 40-bit frame, the one-scan lag of read data, the zero returned for unimplemented reads, the read-back of the chain number, and the count of window pops in a burst closed by an address-0 scan.

// File: rtl/trace_reg_scan.sv
module trace_reg_scan #(
  parameter int IR_W      = 4,
  parameter int CHAIN_W   = 5,
  parameter int ADDR_W    = 7,
  parameter int DATA_W    = 32,
  parameter int NUM_REGS  = 9,
  parameter logic [IR_W-1:0] SEL_IR = 4'h2,
  parameter logic [IR_W-1:0] ACC_IR = 4'hC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IR_W-1:0]   ir_code,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              tdi,
  output logic              tdo,
  output logic              acc_valid,
  output logic              acc_write,
  output logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_wdata,
  input  logic [DATA_W-1:0] acc_rdata
);
  localparam int DR_W = DATA_W + ADDR_W + 1;

  logic [CHAIN_W-1:0] chain_q, sel_sr;
  logic [DR_W-1:0]    acc_sr;
  logic [DATA_W-1:0]  rd_hold;

  wire              sel_on   = (ir_code == SEL_IR);
  wire              acc_on   = (ir_code == ACC_IR) && (chain_q == '0);
  wire [ADDR_W-1:0] sr_addr  = acc_sr[DATA_W +: ADDR_W];
  wire              sr_write = acc_sr[DR_W-1];
  wire              addr_ok  = int'(sr_addr) < NUM_REGS;
  wire              do_upd   = acc_on && update_dr;

  assign tdo = sel_on ? sel_sr[0] : (acc_on ? acc_sr[0] : 1'b0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '1;
      sel_sr  <= '0;
    end else if (sel_on) begin
      if (capture_dr)    sel_sr  <= chain_q;
      else if (shift_dr) sel_sr  <= {tdi, sel_sr[CHAIN_W-1:1]};
      else if (update_dr) chain_q <= sel_sr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      acc_sr <= '0;
    else if (acc_on) begin
      if (capture_dr)    acc_sr <= {1'b0, {ADDR_W{1'b0}}, rd_hold};
      else if (shift_dr) acc_sr <= {tdi, acc_sr[DR_W-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_valid <= 1'b0;
      acc_write <= 1'b0;
      acc_addr  <= '0;
      acc_wdata <= '0;
    end else begin
      acc_valid <= do_upd && addr_ok && !capture_dr && !shift_dr;
      if (do_upd) begin
        acc_write <= sr_write;
        acc_addr  <= sr_addr;
        acc_wdata <= acc_sr[DATA_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      rd_hold <= '0;
    else if (acc_valid && !acc_write)
      rd_hold <= acc_rdata;
    else if (do_upd && !sr_write && !addr_ok)
      rd_hold <= '0;
  end
endmodule

// File: rtl/trace_reg_scan_chk.sv
module trace_reg_scan_chk #(
  parameter int IR_W     = 4,
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 9,
  parameter logic [IR_W-1:0] ACC_IR = 4'hC
) (
  input logic              clk,
  input logic              rst_n,
  input logic [IR_W-1:0]   ir_code,
  input logic              update_dr,
  input logic              acc_valid,
  input logic              acc_write,
  input logic [ADDR_W-1:0] acc_addr,
  input logic [DATA_W-1:0] rd_hold
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> !acc_valid);

  // R5
  single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |=> !acc_valid);

  // R3
  strobe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> ($past(update_dr) && ($past(ir_code) == ACC_IR)));

  // R7
  legal_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    acc_valid |-> (int'(acc_addr) < NUM_REGS));

  // R8
  write_keeps_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_write) |=> $stable(rd_hold));
endmodule

bind trace_reg_scan trace_reg_scan_chk #(
  .IR_W(IR_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
  .NUM_REGS(NUM_REGS), .ACC_IR(ACC_IR)
) u_chk (.*);

// File: tb/trace_reg_scan_bench.sv
module trace_reg_scan_bench;
  logic clk = 0, rst_n = 0;
  logic [3:0] ir_code = 4'hF;
  logic capture_dr = 0, shift_dr = 0, update_dr = 0, tdi = 0;
  logic tdo, acc_valid, acc_write;
  logic [6:0] acc_addr;
  logic [31:0] acc_wdata, acc_rdata;

  int checks = 0, errors = 0, acc_count = 0, pops = 0, rptr = 0;
  bit done = 0;
  logic [31:0] regs [0:15];
  logic [6:0]  last_addr;
  logic [31:0] last_wdata;
  logic        last_write;
  localparam logic [31:0] ID_VAL = 32'h4ABC_0001;

  always #2.5 clk = ~clk;

  trace_reg_scan u_trace_reg_scan (.*);

  function automatic logic [31:0] win(int i);
    return 32'hA500_0000 + 32'(i) * 7;
  endfunction

  always_comb begin
    if (acc_addr == 7'd0)      acc_rdata = ID_VAL;
    else if (acc_addr == 7'd4) acc_rdata = win(rptr);
    else                       acc_rdata = regs[acc_addr[3:0]];
  end

  always @(posedge clk) if (acc_valid) begin
    acc_count++;
    last_addr = acc_addr; last_wdata = acc_wdata; last_write = acc_write;
    if (!acc_write && acc_addr == 7'd4) begin pops++; rptr++; end
    if (acc_write && acc_addr != 7'd0 && acc_addr != 7'd4) regs[acc_addr[3:0]] = acc_wdata;
  end

  task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic scan(int n, logic [39:0] din, output logic [39:0] dout);
    dout = '0;
    @(negedge clk) capture_dr = 1;
    @(negedge clk) capture_dr = 0; shift_dr = 1;
    for (int i = 0; i < n; i++) begin
      dout[i] = tdo; tdi = din[i];
      @(negedge clk);
    end
    shift_dr = 0; update_dr = 1;
    @(negedge clk) update_dr = 0;
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [39:0] fr(bit w, logic [6:0] a, logic [31:0] d);
    return {w, a, d};
  endfunction

  task automatic select_chain(logic [4:0] ch, output logic [4:0] old);
    logic [39:0] o;
    ir_code = 4'h2;
    scan(5, {35'b0, ch}, o);
    old = o[4:0];
    ir_code = 4'hC;
  endtask

  task automatic t_reset();
    logic [39:0] o;
    chk(tdo == 0 && acc_valid == 0, "R1 reset outputs", {tdo, acc_valid}, 0);
    ir_code = 4'hC;
    scan(40, fr(1, 7'd2, 32'h1111_1111), o);
    chk(acc_count == 0, "R1 no access before chain select", acc_count, 0);
  endtask

  task automatic t_select();
    logic [4:0] old;
    select_chain(5'd0, old);
    chk(old == 5'h1F, "R2 capture of reset chain number", old, 5'h1F);
    select_chain(5'd0, old);
    chk(old == 5'h00, "R2 chain number after update", old, 0);
  endtask

  task automatic t_write_read();
    logic [39:0] o;
    int c0 = acc_count;
    scan(40, fr(1, 7'd2, 32'h1234_5678), o);
    chk(acc_count == c0 + 1, "R5 one write strobe", acc_count, c0 + 1);
    chk(last_write && last_addr == 2 && last_wdata == 32'h1234_5678, "R4 R5 write fields",
        {last_write, last_addr, last_wdata}, {1'b1, 7'd2, 32'h1234_5678});
    scan(40, fr(0, 7'd2, 32'h0), o);
    chk(!last_write && last_addr == 2, "R6 read strobe", {last_write, last_addr}, {1'b0, 7'd2});
    scan(40, fr(0, 7'd0, 32'h0), o);
    chk(o == {8'h00, 32'h1234_5678}, "R6 read data one scan late", o, {8'h00, 32'h1234_5678});
    scan(40, fr(0, 7'd0, 32'h0), o);
    chk(o[31:0] == ID_VAL, "R6 next read returns id", o, ID_VAL);
  endtask

  task automatic t_write_keeps();
    logic [39:0] o;
    scan(40, fr(0, 7'd2, 32'h0), o);
    scan(40, fr(1, 7'd3, 32'hCAFE_F00D), o);
    chk(regs[3] == 32'hCAFE_F00D, "R5 write reached register 3", regs[3], 32'hCAFE_F00D);
    scan(40, fr(0, 7'd0, 32'h0), o);
    chk(o[31:0] == 32'h1234_5678, "R8 write keeps held read data", o[31:0], 32'h1234_5678);
  endtask

  task automatic t_unimpl();
    logic [39:0] o;
    int c0 = acc_count;
    scan(40, fr(1, 7'h50, 32'hDEAD_BEEF), o);
    chk(acc_count == c0, "R7 unimplemented write ignored", acc_count, c0);
    scan(40, fr(0, 7'd9, 32'h0), o);
    chk(acc_count == c0, "R7 unimplemented read no strobe", acc_count, c0);
    scan(40, fr(0, 7'd0, 32'h0), o);
    chk(o == 40'h0, "R7 unimplemented read returns zero", o, 0);
  endtask

  task automatic t_burst();
    logic [39:0] o;
    int p0 = pops;
    int r0 = rptr;
    scan(40, fr(0, 7'd4, 32'h0), o);
    for (int k = 0; k < 3; k++) begin
      scan(40, fr(0, (k == 2) ? 7'd0 : 7'd4, 32'h0), o);
      chk(o[31:0] == win(r0 + k), "R9 burst entry order", o[31:0], win(r0 + k));
    end
    chk(pops == p0 + 3, "R9 pop count", pops, p0 + 3);
  endtask

  task automatic t_inactive();
    logic [39:0] o;
    logic [4:0] old;
    int c0 = acc_count;
    select_chain(5'd5, old);
    scan(40, fr(1, 7'd2, 32'h7777_7777), o);
    chk(acc_count == c0 && regs[2] == 32'h1234_5678, "R3 wrong chain blocks access", acc_count, c0);
    chk(o == 40'h0, "R10 tdo low on inactive chain", o, 0);
    ir_code = 4'hF;
    @(negedge clk);
    chk(tdo == 0, "R10 tdo low on other instruction", tdo, 0);
    select_chain(5'd0, old);
    chk(old == 5'd5, "R2 chain five read back", old, 5);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    @(negedge clk) rst_n = 1;
    repeat (2) @(negedge clk);
    t_reset();
    t_select();
    t_write_read();
    t_write_keeps();
    t_unimpl();
    t_burst();
    t_inactive();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule